// File: doc/BRIEF.md
# Dual-Slope Converter Measurement Sequencer

This block holds the timing and counting logic of a dual-slope analog-to-digital converter with a 4.5-digit decimal result. One clock steps it through three phases. Signal integrate lasts a fixed number of clocks. Reference integrate lasts until the comparator reports a zero crossing, or until a cap is reached. Auto-zero fills the rest of a fixed-length measurement cycle. The analog front end gives it two inputs: a zero-crossing strobe and a polarity level. The block returns a busy level, a latched BCD reading, and polarity, overrange and underrange flags. Display scanning is done elsewhere.

With the run input held high, a new cycle starts every `CYCLE_LEN` clocks. If run is low when a cycle ends, the block goes idle and keeps the last reading. Driving run high again starts the next cycle. A run pulse that falls inside a cycle has no effect.

The count of busy clocks always equals the reading plus `SI_LEN + 1`. This is because the first reference clock is never counted. A remote receiver can therefore recover the reading by gating the clock with busy and subtracting that constant.

Top module: `dsadc_sequencer`

## Requirements
- R1: While run is high, busy rises once every `CYCLE_LEN` clocks.
- R2: When run drops during a cycle, that cycle still completes and latches its result. No further cycle starts, and all outputs keep their values while run stays low.
- R3: While idle, the first clock edge that samples run high starts signal integrate, so busy is high right after that edge.
- R4: A run pulse that starts and ends inside a cycle is ignored, and the block goes idle at the end of that cycle.
- R5: Busy covers `SI_LEN` clocks of signal integrate plus every reference clock up to and including the clock in which zero-crossing is sampled high. The number of busy clocks equals the reading plus `SI_LEN + 1`.
- R6: If zero-crossing never arrives, reference integrate stops after `REF_CAP` clocks. The reading is then `REF_CAP - 1` and overrange is set.
- R7: The reading is loaded one clock after busy falls. Its encoding is bits [17:16] = ten-thousands digit (0 to 2), then four BCD nibbles: [15:12] thousands, [11:8] hundreds, [7:4] tens, [3:0] units.
- R8: Overrange stays set through the next signal integrate. It clears on the edge that starts the next reference integrate.
- R9: Underrange is set with the load when the reading is `UR_LIMIT` or less. It clears on the edge that starts the next signal integrate.
- R10: Polarity is sampled on the edge that starts reference integrate and then held. It stays valid for a zero reading.
- R11: During reset, busy is low and the reading and all three flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | High: free-run; low: hold after the current cycle; high again: start |
| zc_i | input | 1 | Comparator zero-crossing strobe |
| pol_i | input | 1 | Comparator polarity, 1 = positive input |
| busy_o | output | 1 | High during signal and reference integrate |
| reading_o | output | 18 | Latched reading, 2-bit top digit plus four BCD decades |
| pol_o | output | 1 | Latched polarity |
| over_o | output | 1 | Overrange flag |
| under_o | output | 1 | Underrange flag |

## Verification
The assertions check several properties on every clock:
- the length of every busy window lies inside the legal range;
- two busy rises are never closer than one cycle;
- the reading and the range flags change only on the clock after busy falls;
- polarity changes only at the start of reference integrate;
- overrange clears only inside busy, and underrange clears only as busy rises.

Some behaviour can only be shown by the bench scenarios, because it depends on what the comparator reports:
- the exact BCD value for a given crossing time;
- the underrange threshold at exactly `UR_LIMIT` and one count above it;
- the capped overrange reading;
- the hold window after run drops, the restart delay, and the rejection of a pulse inside a cycle.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_SIG  = 2'd1,
    PH_REF  = 2'd2,
    PH_ZERO = 2'd3
  } phase_e;

  localparam int DEC_N = 4;
  localparam int MSD_W = 2;
  localparam int RD_W  = MSD_W + 4 * DEC_N;
endpackage

// File: rtl/dsadc_ctrl.sv
module dsadc_ctrl
  import dsadc_pkg::*;
#(
  parameter int SI_LEN    = 10000,
  parameter int REF_CAP   = 20001,
  parameter int CYCLE_LEN = 40002,
  parameter int UR_LIMIT  = 1800
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic zc_i,
  output logic busy_o,
  output logic si_start_o,
  output logic ri_start_o,
  output logic cnt_en_o,
  output logic ld_o,
  output logic ovr_o,
  output logic ur_o
);
  localparam int PH_MAX = (REF_CAP > SI_LEN) ? REF_CAP : SI_LEN;
  localparam int PH_W   = $clog2(PH_MAX + 1);
  localparam int CYC_W  = $clog2(CYCLE_LEN + 1);
  localparam logic [PH_W-1:0]  SI_LAST  = PH_W'(SI_LEN - 1);
  localparam logic [PH_W-1:0]  REF_LAST = PH_W'(REF_CAP - 1);
  localparam logic [PH_W-1:0]  UR_TH    = PH_W'(UR_LIMIT);
  localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(CYCLE_LEN - 1);

  phase_e            phase_q, phase_d;
  logic [CYC_W-1:0]  cyc_q, cyc_d;
  logic [PH_W-1:0]   pcnt_q, pcnt_d;
  logic              ld_q, ovr_q, ovr_d, ur_q, ur_d;
  logic              ri_exit, cap_hit;

  always_comb begin
    phase_d    = phase_q;
    cyc_d      = cyc_q;
    pcnt_d     = pcnt_q;
    si_start_o = 1'b0;
    ri_start_o = 1'b0;
    cnt_en_o   = 1'b0;
    ri_exit    = 1'b0;
    cap_hit    = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (run_i) begin
          phase_d    = PH_SIG;
          cyc_d      = '0;
          pcnt_d     = '0;
          si_start_o = 1'b1;
        end
      end
      PH_SIG: begin
        cyc_d = cyc_q + 1'b1;
        if (pcnt_q == SI_LAST) begin
          phase_d    = PH_REF;
          pcnt_d     = '0;
          ri_start_o = 1'b1;
        end else begin
          pcnt_d = pcnt_q + 1'b1;
        end
      end
      PH_REF: begin
        cyc_d    = cyc_q + 1'b1;
        cnt_en_o = (pcnt_q != '0);
        pcnt_d   = pcnt_q + 1'b1;
        if (zc_i || (pcnt_q == REF_LAST)) begin
          phase_d = PH_ZERO;
          ri_exit = 1'b1;
          cap_hit = !zc_i;
        end
      end
      PH_ZERO: begin
        if (cyc_q == CYC_LAST) begin
          if (run_i) begin
            phase_d    = PH_SIG;
            cyc_d      = '0;
            pcnt_d     = '0;
            si_start_o = 1'b1;
          end else begin
            phase_d = PH_IDLE;
          end
        end else begin
          cyc_d = cyc_q + 1'b1;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_comb begin
    ovr_d = ovr_q;
    ur_d  = ur_q;
    if (ri_exit) begin
      ovr_d = cap_hit;
      ur_d  = !cap_hit && (pcnt_q <= UR_TH);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cyc_q   <= '0;
      pcnt_q  <= '0;
      ld_q    <= 1'b0;
      ovr_q   <= 1'b0;
      ur_q    <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cyc_q   <= cyc_d;
      pcnt_q  <= pcnt_d;
      ld_q    <= ri_exit;
      ovr_q   <= ovr_d;
      ur_q    <= ur_d;
    end
  end

  assign busy_o = (phase_q == PH_SIG) || (phase_q == PH_REF);
  assign ld_o   = ld_q;
  assign ovr_o  = ovr_q;
  assign ur_o   = ur_q;
endmodule

// File: rtl/dsadc_bcd.sv
module dsadc_bcd #(
  parameter int DEC_N = 4,
  parameter int MSD_W = 2,
  localparam int RD_W = MSD_W + 4 * DEC_N
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr_i,
  input  logic            inc_i,
  output logic [RD_W-1:0] val_o
);
  logic [DEC_N:0] carry;
  assign carry[0] = inc_i;

  for (genvar g = 0; g < DEC_N; g++) begin : g_dec
    logic [3:0] dig_q, dig_d;
    always_comb begin
      dig_d = dig_q;
      if (clr_i)          dig_d = 4'd0;
      else if (carry[g])  dig_d = (dig_q == 4'd9) ? 4'd0 : dig_q + 4'd1;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dig_q <= 4'd0;
      else        dig_q <= dig_d;
    end
    assign carry[g+1]     = carry[g] && (dig_q == 4'd9);
    assign val_o[4*g +: 4] = dig_q;
  end

  logic [MSD_W-1:0] msd_q, msd_d;
  always_comb begin
    msd_d = msd_q;
    if (clr_i)             msd_d = '0;
    else if (carry[DEC_N]) msd_d = msd_q + 1'b1;
  end
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) msd_q <= '0;
    else        msd_q <= msd_d;
  end
  assign val_o[RD_W-1 -: MSD_W] = msd_q;
endmodule

// File: rtl/dsadc_latch.sv
module dsadc_latch #(
  parameter int RD_W = 18
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            si_start_i,
  input  logic            ri_start_i,
  input  logic            ld_i,
  input  logic            ovr_i,
  input  logic            ur_i,
  input  logic            pol_i,
  input  logic [RD_W-1:0] bcd_i,
  output logic [RD_W-1:0] reading_o,
  output logic            pol_o,
  output logic            over_o,
  output logic            under_o
);
  logic [RD_W-1:0] rd_q, rd_d;
  logic            pol_q, pol_d, ov_q, ov_d, un_q, un_d;

  always_comb begin
    rd_d  = ld_i ? bcd_i : rd_q;
    pol_d = ri_start_i ? pol_i : pol_q;
    ov_d  = ov_q;
    if (ri_start_i)  ov_d = 1'b0;
    else if (ld_i)   ov_d = ovr_i;
    un_d  = un_q;
    if (si_start_i)  un_d = 1'b0;
    else if (ld_i)   un_d = ur_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      pol_q <= 1'b0;
      ov_q  <= 1'b0;
      un_q  <= 1'b0;
    end else begin
      rd_q  <= rd_d;
      pol_q <= pol_d;
      ov_q  <= ov_d;
      un_q  <= un_d;
    end
  end

  assign reading_o = rd_q;
  assign pol_o     = pol_q;
  assign over_o    = ov_q;
  assign under_o   = un_q;
endmodule

// File: rtl/dsadc_sequencer.sv
module dsadc_sequencer
  import dsadc_pkg::*;
#(
  parameter int SI_LEN    = 10000,
  parameter int REF_CAP   = 20001,
  parameter int CYCLE_LEN = 40002,
  parameter int UR_LIMIT  = 1800
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run_i,
  input  logic            zc_i,
  input  logic            pol_i,
  output logic            busy_o,
  output logic [RD_W-1:0] reading_o,
  output logic            pol_o,
  output logic            over_o,
  output logic            under_o
);
  logic rst_meta, rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sn   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sn   <= rst_meta;
    end
  end

  logic si_start, ri_start, cnt_en, ld, ovr, ur;
  logic [RD_W-1:0] bcd;

  dsadc_ctrl #(
    .SI_LEN(SI_LEN), .REF_CAP(REF_CAP), .CYCLE_LEN(CYCLE_LEN), .UR_LIMIT(UR_LIMIT)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_sn), .run_i(run_i), .zc_i(zc_i),
    .busy_o(busy_o), .si_start_o(si_start), .ri_start_o(ri_start),
    .cnt_en_o(cnt_en), .ld_o(ld), .ovr_o(ovr), .ur_o(ur)
  );

  dsadc_bcd #(.DEC_N(DEC_N), .MSD_W(MSD_W)) u_bcd (
    .clk(clk), .rst_n(rst_sn), .clr_i(ri_start), .inc_i(cnt_en), .val_o(bcd)
  );

  dsadc_latch #(.RD_W(RD_W)) u_latch (
    .clk(clk), .rst_n(rst_sn), .si_start_i(si_start), .ri_start_i(ri_start),
    .ld_i(ld), .ovr_i(ovr), .ur_i(ur), .pol_i(pol_i), .bcd_i(bcd),
    .reading_o(reading_o), .pol_o(pol_o), .over_o(over_o), .under_o(under_o)
  );
endmodule

// File: rtl/dsadc_sequencer_chk.sv
module dsadc_sequencer_chk #(
  parameter int SI_LEN    = 10000,
  parameter int REF_CAP   = 20001,
  parameter int CYCLE_LEN = 40002,
  parameter int RD_W      = 18
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy_o,
  input logic [RD_W-1:0] reading_o,
  input logic            pol_o,
  input logic            over_o,
  input logic            under_o
);
  logic [31:0] blen_q, gap_q;
  logic        busy_d, seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blen_q <= '0;
      gap_q  <= '0;
      busy_d <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      busy_d <= busy_o;
      blen_q <= busy_o ? blen_q + 32'd1 : 32'd0;
      if (busy_o && !busy_d) begin
        gap_q  <= 32'd1;
        seen_q <= 1'b1;
      end else if (gap_q != 32'hFFFF_FFFF) begin
        gap_q <= gap_q + 32'd1;
      end
    end
  end

  assert_cycle_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> (!seen_q || gap_q >= 32'(CYCLE_LEN)));

  assert_busy_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (blen_q >= 32'(SI_LEN + 1)) && (blen_q <= 32'(SI_LEN + REF_CAP)));

  assert_reading_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(reading_o) |-> (!$past(busy_o) && $past(busy_o, 2)));

  assert_over_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(over_o) |-> (!$past(busy_o) && $past(busy_o, 2)));

  assert_over_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(over_o) |-> (busy_o && $past(busy_o)));

  assert_under_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(under_o) |-> (!$past(busy_o) && $past(busy_o, 2)));

  assert_under_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(under_o) |-> $rose(busy_o));

  assert_pol_capture_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pol_o) |-> (busy_o && $past(busy_o)));

  assert_flags_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(over_o && under_o));
endmodule

bind dsadc_sequencer dsadc_sequencer_chk #(
  .SI_LEN(SI_LEN), .REF_CAP(REF_CAP), .CYCLE_LEN(CYCLE_LEN), .RD_W(dsadc_pkg::RD_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy_o(busy_o), .reading_o(reading_o),
  .pol_o(pol_o), .over_o(over_o), .under_o(under_o)
);

// File: tb/dsadc_sequencer_bench.sv
module dsadc_sequencer_bench;
  localparam int CLK_P = 10;
  localparam int SI    = 100;
  localparam int RCAP  = 201;
  localparam int CYC   = 402;
  localparam int URL   = 18;

  logic clk, rst_n, run_i, zc_i, pol_i;
  logic busy_o, pol_o, over_o, under_o;
  logic [17:0] reading_o;

  int checks, errors, tick;
  int blen, t_rise, t_prev, under_first, ov_si_end, ov_ri_start;

  dsadc_sequencer #(.SI_LEN(SI), .REF_CAP(RCAP), .CYCLE_LEN(CYC), .UR_LIMIT(URL)) u_dsadc_sequencer (
    .clk(clk), .rst_n(rst_n), .run_i(run_i), .zc_i(zc_i), .pol_i(pol_i),
    .busy_o(busy_o), .reading_o(reading_o), .pol_o(pol_o),
    .over_o(over_o), .under_o(under_o)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) tick <= tick + 1;

  function automatic int to_bcd(input int v);
    return ((v / 10000) << 16) | (((v / 1000) % 10) << 12) |
           (((v / 100) % 10) << 8) | (((v / 10) % 10) << 4) | (v % 10);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_cycle(input int trip, input logic pol, input int drop_idx, input int pulse_idx);
    int n;
    pol_i = pol;
    while (!busy_o) @(negedge clk);
    n = 0;
    t_prev = t_rise;
    t_rise = tick;
    under_first = under_o;
    ov_si_end = -1;
    ov_ri_start = -1;
    while (busy_o) begin
      if (n == SI - 1) ov_si_end = over_o;
      if (n == SI) ov_ri_start = over_o;
      zc_i = (n == SI + trip);
      if (n == drop_idx) run_i = 1'b0;
      if (pulse_idx >= 0 && n == pulse_idx) run_i = 1'b1;
      else if (pulse_idx >= 0 && n == pulse_idx + 1) run_i = 1'b0;
      n++;
      @(negedge clk);
    end
    zc_i = 1'b0;
    blen = n;
    @(negedge clk);
  endtask

  task automatic t_reset;
    check("R11 busy", busy_o, 0);
    check("R11 reading", reading_o, 0);
    check("R11 flags", {over_o, under_o, pol_o}, 0);
  endtask

  task automatic t_freerun;
    do_cycle(150, 1'b1, -1, -1);
    check("R5 busy length", blen, SI + 150 + 1);
    check("R7 reading 150", reading_o, to_bcd(150));
    check("R10 polarity positive", pol_o, 1);
    check("R6 no overrange", over_o, 0);
    do_cycle(18, 1'b0, -1, -1);
    check("R1 period", t_rise - t_prev, CYC);
    check("R7 reading 18", reading_o, to_bcd(18));
    check("R9 underrange at limit", under_o, 1);
    check("R10 polarity negative", pol_o, 0);
    do_cycle(19, 1'b0, -1, -1);
    check("R9 under cleared at start", under_first, 0);
    check("R9 no underrange above limit", under_o, 0);
    check("R1 period again", t_rise - t_prev, CYC);
    do_cycle(0, 1'b1, -1, -1);
    check("R10 zero reading", reading_o, 0);
    check("R10 polarity with zero", pol_o, 1);
    check("R5 busy length zero", blen, SI + 1);
  endtask

  task automatic t_overrange;
    do_cycle(5000, 1'b1, -1, -1);
    check("R6 capped busy", blen, SI + RCAP);
    check("R6 capped reading", reading_o, to_bcd(RCAP - 1));
    check("R6 overrange set", over_o, 1);
    check("R6 no underrange", under_o, 0);
    do_cycle(50, 1'b0, -1, -1);
    check("R8 over kept in signal phase", ov_si_end, 1);
    check("R8 over cleared at reference", ov_ri_start, 0);
    check("R8 over after normal read", over_o, 0);
    check("R7 reading 50", reading_o, to_bcd(50));
  endtask

  task automatic t_hold;
    int hits;
    do_cycle(60, 1'b1, 5, -1);
    check("R2 cycle completes", reading_o, to_bcd(60));
    hits = 0;
    for (int i = 0; i < CYC + 50; i++) begin
      pol_i = ~pol_i;
      if (busy_o) hits++;
      @(negedge clk);
    end
    check("R2 no new cycle", hits, 0);
    check("R2 reading held", reading_o, to_bcd(60));
    check("R2 polarity held", pol_o, 1);
  endtask

  task automatic t_restart;
    int hits;
    run_i = 1'b1;
    @(negedge clk);
    run_i = 1'b0;
    check("R3 busy after start", busy_o, 1);
    do_cycle(77, 1'b0, -1, 20);
    check("R3 reading after restart", reading_o, to_bcd(77));
    hits = 0;
    for (int i = 0; i < CYC + 50; i++) begin
      if (busy_o) hits++;
      @(negedge clk);
    end
    check("R4 mid-cycle pulse ignored", hits, 0);
    check("R4 reading kept", reading_o, to_bcd(77));
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    checks = 0; errors = 0; tick = 0; t_rise = 0; t_prev = 0;
    rst_n = 1'b0; run_i = 1'b1; zc_i = 1'b0; pol_i = 1'b0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    t_freerun;
    t_overrange;
    t_hold;
    t_restart;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule